// File: doc/BRIEF.md
# Chainable Configurable Logic Cell

This block is a row of small programmable logic cells. Each cell takes three single-bit inputs and produces one output. Static configuration bits choose what the cell computes: a constant low level, a three-input AND, OR or XOR, or the state of an edge-triggered storage element with set and clear. Each input can be inverted before the function, and the result can be inverted after it.

Cells can be chained. When a cell's cascade control is on, its first input is taken from the output of the cell below it; the lowest cell takes it from a dedicated cascade input port. In storage mode, the first pin is the data and the second input acts as the clock. The third input sets the state, and the cascade source, when it is enabled, clears it. The storage element runs from the system clock. It captures data on a detected rising transition of its clock input.

Top module: `lcell_chain`

## Requirements
- R1: Each of the inputs A, B and C of every cell has its own invert bit, applied before the function and also before the storage element's data, clock and set.
- R2: Function code 0 (binary 000) drives a low level. Code 1 (001) gives the AND of the three conditioned inputs, code 2 (010) their OR, and code 3 (011) their XOR. These modes are combinational.
- R3: Function codes 5, 6 and 7 (101 to 111) drive a low level before the output inverter.
- R4: The per-cell output invert bit flips the final output in every mode, including storage mode (code 4, binary 100).
- R5: With cascade on, gate modes use the cascade source in place of pin A, and the A invert bit still applies. Pin A is then ignored. Cell k's cascade source is cell k-1's output, and cell 0's is port `casc_in`.
- R6: In storage mode, when the conditioned B is high at a system clock edge and was low at the previous edge, the conditioned pin A is stored at that edge. The output shows the new value after that edge and not before.
- R7: In storage mode, the stored value does not change while the conditioned B stays high or falls, unless set or clear is active.
- R8: In storage mode, a high conditioned C forces the stored value to 1 at the next system clock edge, whatever B does.
- R9: In storage mode with cascade on, a high cascade source clears the stored value at the next system clock edge. Clear wins over set.
- R10: Synchronous active-low reset clears the stored value. A B input that is already high when reset is released does not count as a rising transition.
- R11: While the function code is not 4, the stored value is held, and set, clear and B transitions have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| casc_in | input | 1 | Cascade source for cell 0 |
| pin_a | input | NCELLS | Input A of each cell |
| pin_b | input | NCELLS | Input B of each cell (storage clock) |
| pin_c | input | NCELLS | Input C of each cell (storage set) |
| inv_a | input | NCELLS | Invert control for input A |
| inv_b | input | NCELLS | Invert control for input B |
| inv_c | input | NCELLS | Invert control for input C |
| inv_y | input | NCELLS | Invert control for the output |
| casc_en | input | NCELLS | Cascade enable of each cell |
| fn_sel | input | 3*NCELLS | Function code of each cell, 3 bits per cell, cell k at bits 3k+2:3k |
| y_out | output | NCELLS | Output of each cell |

## Verification
The storage-element properties assume that every input is synchronous to the system clock and settles between edges. A B transition is only seen as the difference between two successive clock samples. The bench changes every input just after a falling clock edge and never near a rising one. The chain property also assumes that the configuration is quasi-static: it compares levels sampled at one clock edge, so the function and invert bits are changed only in the half cycle before a check.

// File: rtl/lcell_pkg.sv
// lcell_pkg
// Shared constants and the per-cell configuration record for the logic
// cell chain. Assumes a 3-bit function code; codes above FN_FLOP are reserved.
package lcell_pkg;

    localparam int FN_W = 3;

    localparam logic [FN_W-1:0] FN_ZERO = 3'd0;
    localparam logic [FN_W-1:0] FN_AND  = 3'd1;
    localparam logic [FN_W-1:0] FN_OR   = 3'd2;
    localparam logic [FN_W-1:0] FN_XOR  = 3'd3;
    localparam logic [FN_W-1:0] FN_FLOP = 3'd4;

    typedef struct packed {
        logic            inv_a;
        logic            inv_b;
        logic            inv_c;
        logic            inv_y;
        logic            casc_en;
        logic [FN_W-1:0] fn;
    } lcell_cfg_t;

endpackage

// File: rtl/lcell_cond.sv
// lcell_cond
// Input conditioning for one cell. It selects pin A or the cascade source
// for the gate path, applies the per-input inverters, and derives the data
// and clear terms of the storage element.
// Assumes: purely combinational; all inputs synchronous to the system clock.
module lcell_cond (
    input  logic pin_a,
    input  logic pin_b,
    input  logic pin_c,
    input  logic casc_src,
    input  logic inv_a,
    input  logic inv_b,
    input  logic inv_c,
    input  logic casc_en,
    output logic a_eff,
    output logic b_eff,
    output logic c_eff,
    output logic d_ff,
    output logic clr_ff
);

    logic a_src;

    // Purpose: choose the A source, then invert each input as configured.
    always_comb begin
        a_src  = casc_en ? casc_src : pin_a;
        a_eff  = a_src ^ inv_a;
        b_eff  = pin_b ^ inv_b;
        c_eff  = pin_c ^ inv_c;
        d_ff   = pin_a ^ inv_a;
        clr_ff = casc_en & casc_src;
    end

endmodule

// File: rtl/lcell_flop.sv
// lcell_flop
// Storage element of one cell, run by the system clock. A rising transition
// of the clock-like input is found by comparing it with its value at the
// previous edge. Priority: clear, then set, then data capture. The state
// changes only while enabled (storage mode).
// Assumes: all inputs synchronous to clk; rst_n synchronous, active low.
module lcell_flop (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic d,
    input  logic edge_in,
    input  logic set,
    input  logic clr,
    output logic q
);

    logic edge_hist;
    logic edge_rise;

    // Purpose: remember the clock-like input; reset high so a level already
    // present at release is not taken as a rising transition.
    always_ff @(posedge clk) begin
        if (!rst_n) edge_hist <= 1'b1;
        else        edge_hist <= edge_in;
    end

    // Purpose: detect a low-to-high change since the previous edge.
    always_comb edge_rise = edge_in & ~edge_hist;

    // Purpose: update the stored bit with clear over set over capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (en) begin
            if (clr)            q <= 1'b0;
            else if (set)       q <= 1'b1;
            else if (edge_rise) q <= d;
        end
    end

    // R9
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clr) |=> !q);

    // R8
    set_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && set && !clr) |=> q);

    // R6
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !set && !clr && edge_in && !edge_hist) |=> (q == $past(d)));

    // R7
    no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !set && !clr && !(edge_in && !edge_hist)) |=> $stable(q));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q));

endmodule

// File: rtl/lcell_unit.sv
// lcell_unit
// One configurable logic cell: conditioning, function select, storage
// element and output inverter. Gate functions are combinational; the
// storage mode output is the registered state.
// Assumes: cfg is quasi-static.
module lcell_unit
    import lcell_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_a,
    input  logic       pin_b,
    input  logic       pin_c,
    input  logic       casc_src,
    input  lcell_cfg_t cfg,
    output logic       y
);

    logic a_eff, b_eff, c_eff, d_ff, clr_ff;
    logic q;
    logic fn_out;
    logic flop_en;

    lcell_cond u_cond (
        .pin_a    (pin_a),
        .pin_b    (pin_b),
        .pin_c    (pin_c),
        .casc_src (casc_src),
        .inv_a    (cfg.inv_a),
        .inv_b    (cfg.inv_b),
        .inv_c    (cfg.inv_c),
        .casc_en  (cfg.casc_en),
        .a_eff    (a_eff),
        .b_eff    (b_eff),
        .c_eff    (c_eff),
        .d_ff     (d_ff),
        .clr_ff   (clr_ff)
    );

    // Purpose: enable the storage element only in storage mode.
    always_comb flop_en = (cfg.fn == FN_FLOP);

    lcell_flop u_flop (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (flop_en),
        .d       (d_ff),
        .edge_in (b_eff),
        .set     (c_eff),
        .clr     (clr_ff),
        .q       (q)
    );

    // Purpose: select the function result from the configured code.
    always_comb begin
        case (cfg.fn)
            FN_ZERO: fn_out = 1'b0;
            FN_AND:  fn_out = a_eff & b_eff & c_eff;
            FN_OR:   fn_out = a_eff | b_eff | c_eff;
            FN_XOR:  fn_out = a_eff ^ b_eff ^ c_eff;
            FN_FLOP: fn_out = q;
            default: fn_out = 1'b0;
        endcase
    end

    // Purpose: apply the output inverter.
    always_comb y = fn_out ^ cfg.inv_y;

    // R3
    reserved_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.fn > FN_FLOP) |-> (y == cfg.inv_y));

    // R2
    zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.fn == FN_ZERO) |-> (y == cfg.inv_y));

endmodule

// File: rtl/lcell_chain.sv
// lcell_chain
// Top level: NCELLS configurable logic cells. Cell k may take cell k-1's
// output in place of its pin A; cell 0 uses casc_in for this.
// Assumes: configuration ports are static register bits.
module lcell_chain
    import lcell_pkg::*;
#(
    parameter int NCELLS = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     casc_in,
    input  logic [NCELLS-1:0]        pin_a,
    input  logic [NCELLS-1:0]        pin_b,
    input  logic [NCELLS-1:0]        pin_c,
    input  logic [NCELLS-1:0]        inv_a,
    input  logic [NCELLS-1:0]        inv_b,
    input  logic [NCELLS-1:0]        inv_c,
    input  logic [NCELLS-1:0]        inv_y,
    input  logic [NCELLS-1:0]        casc_en,
    input  logic [NCELLS*FN_W-1:0]   fn_sel,
    output logic [NCELLS-1:0]        y_out
);

    localparam int SEL_W = NCELLS * FN_W;

    logic [NCELLS-1:0] cell_y;
    logic [NCELLS-1:0] cell_src;

    for (genvar k = 0; k < NCELLS; k++) begin : g_cell
        lcell_cfg_t cfg_k;

        // Purpose: gather this cell's configuration bits into one record.
        always_comb begin
            cfg_k.inv_a   = inv_a[k];
            cfg_k.inv_b   = inv_b[k];
            cfg_k.inv_c   = inv_c[k];
            cfg_k.inv_y   = inv_y[k];
            cfg_k.casc_en = casc_en[k];
            cfg_k.fn      = fn_sel[k*FN_W +: FN_W];
        end

        if (k == 0) begin : g_first
            // Purpose: the first cell cascades from the external port.
            always_comb cell_src[k] = casc_in;
        end else begin : g_next
            // Purpose: later cells cascade from their lower neighbour.
            always_comb cell_src[k] = cell_y[k-1];

            // R5
            casc_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (casc_en[k] && fn_sel[k*FN_W +: FN_W] == FN_AND && !inv_a[k]
                 && !inv_y[k] && !cell_y[k-1]) |-> !cell_y[k]);
        end

        lcell_unit u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_a    (pin_a[k]),
            .pin_b    (pin_b[k]),
            .pin_c    (pin_c[k]),
            .casc_src (cell_src[k]),
            .cfg      (cfg_k),
            .y        (cell_y[k])
        );
    end

    // Purpose: drive the output port from the cell results.
    always_comb y_out = cell_y;

    // Purpose: elaboration-time sanity of the selector width.
    initial begin
        if (SEL_W != $bits(fn_sel)) $error("fn_sel width mismatch");
    end

endmodule

// File: tb/sim_lcell_chain.sv
module sim_lcell_chain;

    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         casc_in;
    logic [N-1:0] pin_a, pin_b, pin_c, inv_a, inv_b, inv_c, inv_y, casc_en;
    logic [3*N-1:0] fn_sel;
    wire  [N-1:0] y_out;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    lcell_chain #(.NCELLS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .casc_in(casc_in),
        .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c),
        .inv_a(inv_a), .inv_b(inv_b), .inv_c(inv_c), .inv_y(inv_y),
        .casc_en(casc_en), .fn_sel(fn_sel), .y_out(y_out)
    );

    // Fields: fn[10:8] ia[7] ib[6] ic[5] iy[4] a[3] b[2] c[1] expected[0]
    localparam logic [10:0] VEC [17] = '{
        {3'd1, 4'b0000, 3'b111, 1'b1},
        {3'd1, 4'b0000, 3'b110, 1'b0},
        {3'd1, 4'b0010, 3'b110, 1'b1},
        {3'd1, 4'b1110, 3'b000, 1'b1},
        {3'd2, 4'b0000, 3'b000, 1'b0},
        {3'd2, 4'b0000, 3'b001, 1'b1},
        {3'd2, 4'b0001, 3'b000, 1'b1},
        {3'd2, 4'b0100, 3'b000, 1'b1},
        {3'd3, 4'b0000, 3'b111, 1'b1},
        {3'd3, 4'b0000, 3'b110, 1'b0},
        {3'd3, 4'b1000, 3'b110, 1'b1},
        {3'd3, 4'b0001, 3'b100, 1'b0},
        {3'd0, 4'b0000, 3'b111, 1'b0},
        {3'd0, 4'b0001, 3'b000, 1'b1},
        {3'd5, 4'b0000, 3'b111, 1'b0},
        {3'd6, 4'b1110, 3'b000, 1'b0},
        {3'd7, 4'b0001, 3'b111, 1'b1}
    };

    task automatic check(input logic got, input logic exp, input string req);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        rst_n = 1'b0; casc_in = 1'b0;
        pin_a = '0; pin_b = '0; pin_c = '0;
        inv_a = '0; inv_b = '0; inv_c = '0; inv_y = '0; casc_en = '0;
        fn_sel = '0;
        fn_sel[2:0] = 3'd4; pin_a[0] = 1'b1; pin_b[0] = 1'b1;
        step(); step(); step();
        check(y_out[0], 1'b0, "R10");          // state cleared in reset
        rst_n = 1'b1;
        step(); step();
        check(y_out[0], 1'b0, "R10");          // B high at release: no edge

        // Table of gate-mode vectors on cell 0
        for (int i = 0; i < 17; i++) begin
            logic [10:0] v;
            string tag;
            v = VEC[i];
            fn_sel[2:0] = v[10:8];
            inv_a[0] = v[7]; inv_b[0] = v[6]; inv_c[0] = v[5]; inv_y[0] = v[4];
            pin_a[0] = v[3]; pin_b[0] = v[2]; pin_c[0] = v[1];
            step();
            if (v[10:8] > 3'd4)     tag = "R3";
            else if (v[7:5] != 0)   tag = "R1";
            else if (v[4])          tag = "R4";
            else                    tag = "R2";
            check(y_out[0], v[0], tag);
        end

        // Storage mode on cell 0
        inv_a[0] = 0; inv_b[0] = 0; inv_c[0] = 0; inv_y[0] = 0;
        fn_sel[2:0] = 3'd4; pin_a[0] = 1; pin_b[0] = 0; pin_c[0] = 0;
        step();
        pin_b[0] = 1;
        #1 check(y_out[0], 1'b0, "R6");         // not before the edge
        step();
        check(y_out[0], 1'b1, "R6");            // captured A=1
        pin_a[0] = 0;
        step(); step();
        check(y_out[0], 1'b1, "R7");            // B held high
        pin_b[0] = 0;
        step();
        check(y_out[0], 1'b1, "R7");            // B falling
        pin_b[0] = 1;
        step();
        check(y_out[0], 1'b0, "R6");            // captured A=0
        pin_c[0] = 1;
        step();
        check(y_out[0], 1'b1, "R8");            // set without B edge
        casc_en[0] = 1; casc_in = 1;
        step();
        check(y_out[0], 1'b0, "R9");            // clear beats set
        casc_in = 0;
        step();
        check(y_out[0], 1'b1, "R8");
        pin_c[0] = 0; casc_en[0] = 0;

        // R11: leave storage mode, disturb, return
        fn_sel[2:0] = 3'd1; casc_en[0] = 1; casc_in = 1; pin_c[0] = 1;
        pin_b[0] = 0; step();
        pin_b[0] = 1; step(); step();
        casc_en[0] = 0; casc_in = 0; pin_c[0] = 0; fn_sel[2:0] = 3'd4;
        step();
        check(y_out[0], 1'b1, "R11");
        inv_y[0] = 1;
        step();
        check(y_out[0], 1'b0, "R4");            // inverter in storage mode
        inv_y[0] = 0;

        // R1: inverted clock and data in storage mode
        pin_a[0] = 0; inv_b[0] = 1;             // conditioned B low
        step();
        pin_b[0] = 0;                           // conditioned B rises
        step();
        check(y_out[0], 1'b0, "R1");
        inv_a[0] = 1; pin_b[0] = 1;
        step();
        pin_b[0] = 0;
        step();
        check(y_out[0], 1'b1, "R1");
        inv_a[0] = 0; inv_b[0] = 0;

        // R5: cascade between cells and from the port
        fn_sel[2:0] = 3'd0; inv_y[0] = 1;
        fn_sel[5:3] = 3'd1; casc_en[1] = 1;
        pin_a[1] = 0; pin_b[1] = 1; pin_c[1] = 1;
        step();
        check(y_out[1], 1'b1, "R5");
        inv_y[0] = 0;
        step();
        check(y_out[1], 1'b0, "R5");
        inv_a[1] = 1;
        step();
        check(y_out[1], 1'b1, "R5");
        inv_a[1] = 0;
        fn_sel[2:0] = 3'd2; casc_en[0] = 1;
        pin_a[0] = 0; pin_b[0] = 0; pin_c[0] = 0; casc_in = 1;
        step();
        check(y_out[0], 1'b1, "R5");
        casc_in = 0; pin_a[0] = 1;
        step();
        check(y_out[0], 1'b0, "R5");            // pin A ignored

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

endmodule